// File: doc/BRIEF.md
# Variable-Length Vector Arithmetic Unit

This unit applies one elementwise operation to two vectors held in an on-chip scratchpad and writes the result vector back to the same scratchpad. The vector length is not fixed by any register width. Software places the length and the base addresses in scalar registers, and the unit receives them with a start pulse. Elements are signed 16-bit values. The datapath is 32 lanes wide, so each scratchpad row holds 32 elements. The unit walks the vector one row at a time. On the final row it writes only the lanes that fall inside the length.

Five operations are supported:
- add one vector to another
- add a broadcast scalar to a vector
- multiply two vectors
- greater-than merge, which keeps the larger element of each pair and is used for max pooling
- divide one vector by another

Add and multiply saturate. Divide uses a bit-serial divider in every lane, so a divide row takes extra cycles.

The scratchpad itself sits outside the unit. It has two read ports with one cycle of read latency and one write port with a per-lane write mask. All addresses are row addresses. A 64 KB scratchpad has 1024 rows of 32 x 16 bits.

Top module: `vec_unit`

## Requirements
- R1: While reset is held, and after its release until the first start, busy, done, rd_en and wr_en are all 0.
- R2: Opcode 0 writes the saturating signed sum a[i]+b[i] into each element, where a is read from the src0 rows and b from the src1 rows. Sums above 32767 give 32767, and sums below -32768 give -32768.
- R3: Opcode 1 writes the saturating sum a[i]+scalar into each element, using the same scalar for every element.
- R4: Opcode 2 writes the saturating signed product a[i]*b[i] into each element.
- R5: Opcode 3 writes a[i] when a[i] > b[i] as signed values, and writes b[i] otherwise.
- R6: Opcode 4 writes the quotient a[i]/b[i], truncated toward zero. A quotient of 32768 (from -32768 / -1) saturates to 32767. When b[i] = 0, the result is 32767 if a[i] >= 0 and -32768 if a[i] < 0.
- R7: Element k of a vector lives in row base+k/32, lane k%32, where lane j occupies wr_data bits 16j+15..16j. On a final row that is partially used, the mask covers only lanes 0 to len-1-32*(rows before it). Lanes outside the mask, and rows past the last row, stay unchanged.
- R8: A start with length 0 raises done in the next cycle, keeps busy low, and issues no read and no write.
- R9: For a nonzero length, busy is 1 from the cycle after the start until the last write. Done is 1 for exactly the one cycle that follows the cycle carrying the last write.
- R10: A start that arrives while busy is 1 is ignored. The running command finishes unchanged, and the ignored command writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command when idle |
| op | input | 3 | Operation code (0 add, 1 add scalar, 2 multiply, 3 max merge, 4 divide; other codes are reserved) |
| src0 | input | AW | First source base row |
| src1 | input | AW | Second source base row |
| scalar | input | EW | Broadcast operand for opcode 1 |
| dst | input | AW | Destination base row |
| len | input | LW | Element count |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Scratchpad read request |
| rd_addr0 | output | AW | Row address for the first operand |
| rd_addr1 | output | AW | Row address for the second operand |
| rd_data0 | input | LANES*EW | First operand row, valid the cycle after rd_en |
| rd_data1 | input | LANES*EW | Second operand row, valid the cycle after rd_en |
| wr_en | output | 1 | Scratchpad write |
| wr_addr | output | AW | Destination row address |
| wr_mask | output | LANES | Per-lane write enable |
| wr_data | output | LANES*EW | Result row |

## Verification
The source pattern places extreme values in fixed lanes. This exercises overflow in both directions on add and multiply, -32768 divided by -1, and division by zero with a positive, negative and zero dividend. A design without saturation would show wrapped values in those lanes, and a design with the wrong zero-divisor rule would show the wrong sign.

Lengths of 1, 33, 40, 45 and 70 exercise the partial final row. Each check covers one row past the end, so an off-by-one mask would appear as a changed sentinel or a missing element.

A zero-length command must finish in one cycle with no traffic, and a start issued during a busy command must not disturb that command. A design that ignored either rule would either access the scratchpad or write the second command's destination.

// File: rtl/vec_unit.sv
module vec_unit #(
  parameter int LANES = 32,
  parameter int EW    = 16,
  parameter int AW    = 10,
  parameter int LW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            op,
  input  logic [AW-1:0]         src0,
  input  logic [AW-1:0]         src1,
  input  logic [EW-1:0]         scalar,
  input  logic [AW-1:0]         dst,
  input  logic [LW-1:0]         len,
  output logic                  busy,
  output logic                  done,
  output logic                  rd_en,
  output logic [AW-1:0]         rd_addr0,
  output logic [AW-1:0]         rd_addr1,
  input  logic [LANES*EW-1:0]   rd_data0,
  input  logic [LANES*EW-1:0]   rd_data1,
  output logic                  wr_en,
  output logic [AW-1:0]         wr_addr,
  output logic [LANES-1:0]      wr_mask,
  output logic [LANES*EW-1:0]   wr_data
);

  localparam int QW = EW + 1;
  localparam int CW = $clog2(QW + 1);
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADDS = 3'd1, OP_MUL = 3'd2, OP_MAX = 3'd3, OP_DIV = 3'd4;
  localparam logic [EW-1:0] SMAX = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] SMIN = {1'b1, {(EW-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_RD, S_EX, S_DV} st_t;

  st_t            st;
  logic [2:0]     op_q;
  logic [AW-1:0]  a_q, b_q, d_q, off_q;
  logic [EW-1:0]  sc_q;
  logic [LW-1:0]  rem_q;
  logic [CW-1:0]  cnt_q;
  logic           done_q;

  function automatic logic [EW-1:0] sat(input logic signed [2*EW-1:0] v);
    if (v > $signed({{EW{1'b0}}, SMAX})) return SMAX;
    if (v < $signed({{EW{1'b1}}, SMIN})) return SMIN;
    return v[EW-1:0];
  endfunction

  wire last     = rem_q <= LW'(LANES);
  wire div_wr   = (st == S_DV) && (cnt_q == CW'(QW));
  assign busy     = st != S_IDLE;
  assign done     = done_q;
  assign rd_en    = st == S_RD;
  assign rd_addr0 = a_q + off_q;
  assign rd_addr1 = b_q + off_q;
  assign wr_addr  = d_q + off_q;
  assign wr_en    = ((st == S_EX) && (op_q != OP_DIV)) || div_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [EW-1:0]   a, b;
    logic signed [2*EW-1:0] ea, eb, sum, prod, ma, mb;
    logic [EW:0]            r, q, d, sh, qn;
    logic                   na, nq, zq;
    logic [EW-1:0]          dres, res;

    assign a    = rd_data0[g*EW +: EW];
    assign b    = (op_q == OP_ADDS) ? sc_q : rd_data1[g*EW +: EW];
    assign ea   = {{EW{a[EW-1]}}, a};
    assign eb   = {{EW{b[EW-1]}}, b};
    assign sum  = ea + eb;
    assign prod = ea * eb;
    assign ma   = a[EW-1] ? -ea : ea;
    assign mb   = b[EW-1] ? -eb : eb;
    assign sh   = {r[EW-1:0], q[EW]};
    assign qn   = -q;

    always_ff @(posedge clk) begin
      if (st == S_EX) begin
        q  <= ma[EW:0];
        d  <= mb[EW:0];
        r  <= '0;
        na <= a[EW-1];
        nq <= a[EW-1] ^ b[EW-1];
        zq <= (b == '0);
      end else if (st == S_DV && cnt_q < CW'(QW)) begin
        if (sh >= d) begin
          r <= sh - d;
          q <= {q[EW-1:0], 1'b1};
        end else begin
          r <= sh;
          q <= {q[EW-1:0], 1'b0};
        end
      end
    end

    assign dres = zq ? (na ? SMIN : SMAX)
                : nq ? qn[EW-1:0]
                : (q > {1'b0, SMAX}) ? SMAX : q[EW-1:0];

    always_comb begin
      case (op_q)
        OP_MUL:  res = sat(prod);
        OP_MAX:  res = (a > b) ? a : b;
        OP_DIV:  res = dres;
        default: res = sat(sum);
      endcase
    end

    assign wr_data[g*EW +: EW] = res;
    assign wr_mask[g] = rem_q > LW'(g);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done_q <= 1'b0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      d_q    <= '0;
      sc_q   <= '0;
      rem_q  <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q  <= op;
          a_q   <= src0;
          b_q   <= src1;
          d_q   <= dst;
          sc_q  <= scalar;
          rem_q <= len;
          off_q <= '0;
          if (len == '0) done_q <= 1'b1;
          else           st     <= S_RD;
        end
        S_RD: st <= S_EX;
        default: begin
          if (st == S_EX && op_q == OP_DIV) begin
            cnt_q <= '0;
            st    <= S_DV;
          end else if (st == S_DV && !div_wr) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            rem_q <= rem_q - LW'(LANES);
            off_q <= off_q + 1'b1;
            st    <= S_RD;
          end
        end
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_write_busy: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> busy);
  a_r7_mask_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_mask[0] && ((wr_mask & (wr_mask + 1'b1)) == '0)));
  a_r7_partial_last: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mask[LANES-1]) |=> done);
  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len == '0) |=> (done && !busy && !rd_en && !wr_en));
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en) |=> busy);

endmodule

// File: tb/test_vec_unit.sv
`timescale 1ns/1ps
module test_vec_unit;
  localparam int LANES = 32, EW = 16, AW = 10, LW = 16;
  localparam logic [15:0] SENT = 16'h5A5A;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] len;
    logic [9:0]  s0;
    logic [9:0]  s1;
    logic [9:0]  d;
    logic [15:0] sc;
  } cmd_t;

  localparam int NT = 9;
  localparam cmd_t TBL [NT] = '{
    {3'd0, 16'd70,  10'd0,  10'd16, 10'd32, 16'd0},
    {3'd1, 16'd32,  10'd2,  10'd16, 10'd36, 16'd1000},
    {3'd1, 16'd45,  10'd5,  10'd16, 10'd40, 16'h8AD0},
    {3'd2, 16'd96,  10'd1,  10'd17, 10'd33, 16'd0},
    {3'd3, 16'd33,  10'd3,  10'd20, 10'd44, 16'd0},
    {3'd4, 16'd40,  10'd0,  10'd16, 10'd34, 16'd0},
    {3'd3, 16'd1,   10'd7,  10'd21, 10'd45, 16'd0},
    {3'd4, 16'd64,  10'd8,  10'd24, 10'd38, 16'd0},
    {3'd0, 16'd128, 10'd10, 10'd26, 10'd41, 16'd0}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0;
  logic [AW-1:0] src0 = 0, src1 = 0, dst = 0;
  logic [EW-1:0] scalar = 0;
  logic [LW-1:0] len = 0;
  logic busy, done, rd_en, wr_en;
  logic [AW-1:0] rd_addr0, rd_addr1, wr_addr;
  logic [LANES*EW-1:0] rd_data0, rd_data1, wr_data;
  logic [LANES-1:0] wr_mask;
  logic [LANES*EW-1:0] mem [64];
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  vec_unit #(.LANES(LANES), .EW(EW), .AW(AW), .LW(LW)) i_vec_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src0(src0), .src1(src1),
    .scalar(scalar), .dst(dst), .len(len), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_data0(rd_data0), .rd_data1(rd_data1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data));

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data0 <= mem[rd_addr0[5:0]];
      rd_data1 <= mem[rd_addr1[5:0]];
    end
    if (wr_en)
      for (int l = 0; l < LANES; l++)
        if (wr_mask[l]) mem[wr_addr[5:0]][l*EW +: EW] <= wr_data[l*EW +: EW];
  end

  function automatic logic [15:0] initv(int row, int lane);
    logic [31:0] h;
    h = row * 32'd1103515245 + lane * 32'd12345 + 32'd977;
    if (row >= 32) return SENT;
    if (row < 16) begin
      if (lane == 0 && row % 2 == 0) return 16'h8000;
      if (lane == 1) return 16'h7FFF;
      if (lane == 2) return 16'h0000;
      if (lane == 4) return 16'hFFFB;
    end else begin
      if (lane == 0) return (row % 2 == 0) ? 16'hFFFF : 16'h0001;
      if (lane == 1) return 16'h0001;
      if (lane == 2 || lane == 3) return 16'h0000;
      if (lane == 5) return 16'hFFFD;
    end
    return h[23:8];
  endfunction

  function automatic logic [15:0] sat16(int v);
    if (v > 32767) return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return 16'(v);
  endfunction

  function automatic logic [15:0] ref_op(int opc, int a, int b);
    case (opc)
      2: return sat16(a * b);
      3: return (a > b) ? 16'(a) : 16'(b);
      4: if (b == 0) return (a < 0) ? 16'h8000 : 16'h7FFF;
         else return sat16(a / b);
      default: return sat16(a + b);
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int r = 0; r < 64; r++)
      for (int l = 0; l < LANES; l++) mem[r][l*EW +: EW] = initv(r, l);
  endtask

  task automatic issue(cmd_t c);
    @(negedge clk);
    start = 1; op = c.op; len = c.len; src0 = c.s0; src1 = c.s1; dst = c.d; scalar = c.sc;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0, lastw = -10;
    check({req, " busy after start"}, 16'(busy), 16'd1);
    while (!done && n < 3000) begin
      if (wr_en) lastw = n;
      @(negedge clk);
      n++;
    end
    check({req, " done follows last write"}, 16'(n), 16'(lastw + 1));
    @(negedge clk);
    check({req, " done one cycle"}, 16'(done), 16'd0);
    check({req, " idle after done"}, 16'(busy), 16'd0);
  endtask

  task automatic verify(cmd_t c, string req);
    int nrow = (int'(c.len) + 31) / 32 + 1;
    for (int r = 0; r < nrow; r++)
      for (int l = 0; l < LANES; l++) begin
        int idx = r * 32 + l;
        logic [15:0] exp;
        if (idx < int'(c.len)) begin
          int a = int'($signed(initv(int'(c.s0) + idx / 32, idx % 32)));
          int b = (c.op == 3'd1) ? int'($signed(c.sc))
                                 : int'($signed(initv(int'(c.s1) + idx / 32, idx % 32)));
          exp = ref_op(int'(c.op), a, b);
        end else exp = SENT;
        check(req, mem[int'(c.d) + r][l*EW +: EW], exp);
      end
  endtask

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0: return "R2/R7";
      3'd1: return "R3/R7";
      3'd2: return "R4/R7";
      3'd3: return "R5/R7";
      default: return "R6/R7";
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cmd_t z, c1, c2;
    init_mem();
    repeat (3) @(negedge clk);
    check("R1 reset busy", 16'(busy), 0);
    check("R1 reset done", 16'(done), 0);
    check("R1 reset rd_en", 16'(rd_en), 0);
    check("R1 reset wr_en", 16'(wr_en), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", 16'({busy, done, rd_en, wr_en}), 0);

    for (int t = 0; t < NT; t++) begin
      init_mem();
      issue(TBL[t]);
      wait_done("R9");
      verify(TBL[t], req_of(TBL[t].op));
    end

    init_mem();
    z = '{op: 3'd0, len: 16'd0, s0: 10'd0, s1: 10'd16, d: 10'd32, sc: 16'd0};
    issue(z);
    check("R8 done next cycle", 16'(done), 1);
    check("R8 busy stays low", 16'(busy), 0);
    check("R8 no access", 16'({rd_en, wr_en}), 0);
    @(negedge clk);
    check("R8 done single", 16'(done), 0);
    check("R8 no access later", 16'({rd_en, wr_en}), 0);
    check("R8 destination untouched", mem[32][15:0], SENT);

    init_mem();
    c1 = '{op: 3'd0, len: 16'd64, s0: 10'd0, s1: 10'd16, d: 10'd32, sc: 16'd0};
    c2 = '{op: 3'd3, len: 16'd32, s0: 10'd4, s1: 10'd18, d: 10'd50, sc: 16'd0};
    issue(c1);
    @(negedge clk);
    start = 1; op = c2.op; len = c2.len; src0 = c2.s0; src1 = c2.s1; dst = c2.d;
    @(negedge clk);
    start = 0;
    wait_done("R10");
    verify(c1, "R10");
    for (int l = 0; l < LANES; l++) check("R10 ignored start wrote nothing", mem[50][l*EW +: EW], SENT);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule